// File: doc/BRIEF.md
# Programmable Asynchronous Memory Strobe Sequencer

This block drives one access at a time to an external asynchronous memory. It has two or more chip selects. Each chip select holds its own set of timing fields, written through a simple configuration port. A request supplies an address, a read/write flag and write data. The block matches the address against the base address of each enabled chip select. If one matches, the block takes a snapshot of that chip select's settings. It then runs a tick counter that starts at zero, and derives the active-low chip-select, address-valid, output-enable and write-enable strobes from that counter. A strobe is active while the count is at or above its assertion tick and below its deassertion tick.

The tick rate is the functional clock divided by 1, 2, 3 or 4. On a read, the block samples the memory's data bus at the programmed access tick. The cycle ends when the count equals the programmed cycle length, which is set separately for reads and writes. The block then returns to idle and raises a one-clock completion pulse. If a request matches no enabled chip select, the block raises a one-clock error pulse instead, and no strobe moves. A per-chip-select multiplexed mode places the low address bits on the data bus while address valid is active.

Top module: `amt_engine`

## Requirements
- R1: The configuration port writes word `cfg_word` of chip select `cfg_cs` when `cfg_we` is high. The words are laid out as follows:
  - Word 0: [1:0] divisor minus one, [2] multiplexed mode, [3] enable, [12:8] base address.
  - Word 1 (chip select): [3:0] assert tick, [12:8] read deassert tick, [20:16] write deassert tick.
  - Word 2 (address valid): the same layout as word 1.
  - Word 3: [3:0] output-enable assert tick, [12:8] output-enable deassert tick, [19:16] write-enable assert tick, [28:24] write-enable deassert tick.
  - Word 4: [4:0] read cycle length, [12:8] write cycle length, [20:16] access tick.
  - All fields reset to zero.
- R2: The selected `mem_cs_n` bit is low exactly while the tick count c satisfies on <= c < off. The deassertion point is the read one for reads and the write one for writes. All other chip-select bits stay high.
- R3: `mem_adv_n` follows the same window rule with its own assertion tick and its own read and write deassertion ticks.
- R4: `mem_oe_n` uses its window on reads only. `mem_we_n` uses its window on writes only. The two are never low together.
- R5: One tick lasts divisor clocks. In clock k of the access (k = 0 being the clock after acceptance), the count is k / divisor.
- R6: The access ends in the clock where the count equals the cycle length. `done` is high for exactly the next clock, in which the block is idle with all strobes high. An access therefore spans length*divisor+1 clocks.
- R7: On a read, `rd_data` takes the value on `mem_din` in the first clock of the access tick. It holds that value while `done` is high.
- R8: A chip select matches when it is enabled and its base equals `req_addr[28:24]`. When several match, the lowest index wins. At most one `mem_cs_n` bit is low.
- R9: A request that matches no enabled chip select starts no access. `err` is high for one clock, in the clock after the request, and every strobe stays high.
- R10: A request is accepted only when idle. A request raised during an access does not change that access, and no second access follows it.
- R11: `mem_dout_en` is high while the address window is active in multiplexed mode, and also on a write while chip select is active. In the first case `mem_dout` carries `req_addr[15:0]`; otherwise it carries the write data.
- R12: During reset and while idle, all strobes are high and `done`, `err` and `mem_dout_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cs | input | $clog2(NUM_CS) | Chip select being configured |
| cfg_word | input | 3 | Configuration word index |
| cfg_wdata | input | 32 | Configuration word value |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock no-match pulse |
| rd_data | output | DATA_W | Captured read data |
| mem_cs_n | output | NUM_CS | Chip-select strobes, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Address of the current access |
| mem_dout | output | DATA_W | Data (or multiplexed address) to memory |
| mem_dout_en | output | 1 | Drive enable for mem_dout |
| mem_din | input | DATA_W | Data from memory |

## Verification
The bench sweeps all four divisors against three timing sets for both reads and writes. It compares every strobe in every clock against windows it computes by arithmetic.
- The first timing set has ordinary nested windows.
- The second set enables multiplexed mode, which separates address-phase and data-phase drive.
- The third set holds the edge cases: deassert ticks past the cycle end, empty windows, and an access tick equal to the cycle length.

While `mem_din` changes every clock, the captured read word shows the exact sampling clock. A request poked in the middle of an access shows that busy requests are ignored. Unmatched, disabled and duplicate-base addresses separate the error path from the priority rule.

// File: rtl/amt_pkg.sv
package amt_pkg;

  localparam int TICK_W = 5;
  localparam int ON_W   = 4;
  localparam int BASE_W = 5;

  typedef struct packed {
    logic [1:0]        div_m1;
    logic              muxed;
    logic              en;
    logic [BASE_W-1:0] base;
    logic [ON_W-1:0]   cs_on;
    logic [TICK_W-1:0] cs_rd_off;
    logic [TICK_W-1:0] cs_wr_off;
    logic [ON_W-1:0]   adv_on;
    logic [TICK_W-1:0] adv_rd_off;
    logic [TICK_W-1:0] adv_wr_off;
    logic [ON_W-1:0]   oe_on;
    logic [TICK_W-1:0] oe_off;
    logic [ON_W-1:0]   we_on;
    logic [TICK_W-1:0] we_off;
    logic [TICK_W-1:0] rd_len;
    logic [TICK_W-1:0] wr_len;
    logic [TICK_W-1:0] acc_tick;
  } cs_cfg_t;

  typedef enum logic {ST_IDLE, ST_RUN} seq_st_t;

  function automatic logic in_window(input logic [TICK_W-1:0] cnt,
                                     input logic [ON_W-1:0]   on_t,
                                     input logic [TICK_W-1:0] off_t);
    return (cnt >= {1'b0, on_t}) && (cnt < off_t);
  endfunction

endpackage

// File: rtl/amt_cfg_bank.sv
module amt_cfg_bank
  import amt_pkg::*;
#(
  parameter int NUM_CS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [$clog2(NUM_CS)-1:0] wr_cs_i,
  input  logic [2:0]                wr_word_i,
  input  logic [31:0]               wr_data_i,
  output cs_cfg_t [NUM_CS-1:0]      cfg_o
);
  localparam int SEL_W = $clog2(NUM_CS);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_bank
    cs_cfg_t bank_q, bank_d;
    logic    wr_hit;

    assign wr_hit = wr_en_i && (wr_cs_i == SEL_W'(g));

    always_comb begin
      bank_d = bank_q;
      case (wr_word_i)
        3'd0: begin
          bank_d.div_m1 = wr_data_i[1:0];
          bank_d.muxed  = wr_data_i[2];
          bank_d.en     = wr_data_i[3];
          bank_d.base   = wr_data_i[12:8];
        end
        3'd1: begin
          bank_d.cs_on     = wr_data_i[3:0];
          bank_d.cs_rd_off = wr_data_i[12:8];
          bank_d.cs_wr_off = wr_data_i[20:16];
        end
        3'd2: begin
          bank_d.adv_on     = wr_data_i[3:0];
          bank_d.adv_rd_off = wr_data_i[12:8];
          bank_d.adv_wr_off = wr_data_i[20:16];
        end
        3'd3: begin
          bank_d.oe_on  = wr_data_i[3:0];
          bank_d.oe_off = wr_data_i[12:8];
          bank_d.we_on  = wr_data_i[19:16];
          bank_d.we_off = wr_data_i[28:24];
        end
        3'd4: begin
          bank_d.rd_len   = wr_data_i[4:0];
          bank_d.wr_len   = wr_data_i[12:8];
          bank_d.acc_tick = wr_data_i[20:16];
        end
        default: bank_d = bank_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bank_q <= '0;
      else if (wr_hit) bank_q <= bank_d;
    end

    assign cfg_o[g] = bank_q;
  end

endmodule

// File: rtl/amt_cs_decode.sv
module amt_cs_decode
  import amt_pkg::*;
#(
  parameter int NUM_CS   = 2,
  parameter int ADDR_W   = 32,
  parameter int BASE_LSB = 24
) (
  input  cs_cfg_t [NUM_CS-1:0]      cfg_i,
  input  logic [ADDR_W-1:0]         addr_i,
  output logic                      hit_o,
  output logic [$clog2(NUM_CS)-1:0] sel_o
);
  localparam int SEL_W = $clog2(NUM_CS);

  logic [BASE_W-1:0] addr_base;
  assign addr_base = addr_i[BASE_LSB +: BASE_W];

  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (cfg_i[i].en && (cfg_i[i].base == addr_base)) begin
        hit_o = 1'b1;
        sel_o = SEL_W'(i);
      end
    end
  end

  // R8: a reported match must name an enabled bank whose base is the one addressed
  always_comb begin
    if (hit_o) begin
      assert_hit_enabled_R8: assert (cfg_i[sel_o].en && (cfg_i[sel_o].base == addr_base));
    end
  end

endmodule

// File: rtl/amt_tick_gen.sv
module amt_tick_gen
  import amt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              run_i,
  input  logic [1:0]        div_m1_i,
  output logic [TICK_W-1:0] cnt_o,
  output logic              first_o
);
  logic [1:0]        pre_q, pre_d;
  logic [TICK_W-1:0] cnt_q, cnt_d;
  logic              ld;

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    ld    = 1'b0;
    if (start_i) begin
      pre_d = '0;
      cnt_d = '0;
      ld    = 1'b1;
    end else if (run_i) begin
      ld = 1'b1;
      if (pre_q == div_m1_i) begin
        pre_d = '0;
        if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (ld) begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign first_o = (pre_q == 2'd0);

  // R5: while running, the count either holds or advances by exactly one
  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !start_i && (cnt_q != '1)) |=>
      ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));

  // R5: the count advances only after the prescaler has wrapped
  assert_tick_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !start_i && (pre_q != div_m1_i)) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/amt_engine.sv
module amt_engine
  import amt_pkg::*;
#(
  parameter int NUM_CS   = 2,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 16,
  parameter int BASE_LSB = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NUM_CS)-1:0] cfg_cs,
  input  logic [2:0]                cfg_word,
  input  logic [31:0]               cfg_wdata,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      done,
  output logic                      err,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_CS-1:0]         mem_cs_n,
  output logic                      mem_adv_n,
  output logic                      mem_oe_n,
  output logic                      mem_we_n,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_dout,
  output logic                      mem_dout_en,
  input  logic [DATA_W-1:0]         mem_din
);
  localparam int SEL_W = $clog2(NUM_CS);

  cs_cfg_t [NUM_CS-1:0] cfg_all;
  logic                 hit;
  logic [SEL_W-1:0]     hit_sel;

  amt_cfg_bank #(.NUM_CS(NUM_CS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (cfg_we),
    .wr_cs_i   (cfg_cs),
    .wr_word_i (cfg_word),
    .wr_data_i (cfg_wdata),
    .cfg_o     (cfg_all)
  );

  amt_cs_decode #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_dec (
    .cfg_i  (cfg_all),
    .addr_i (req_addr),
    .hit_o  (hit),
    .sel_o  (hit_sel)
  );

  seq_st_t           st_q, st_d;
  cs_cfg_t           cur_q;
  logic              wr_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdat_q;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              running, accept, launch, at_end, capture;
  logic [TICK_W-1:0] cnt, len;
  logic              first;

  assign running = (st_q == ST_RUN);
  assign accept  = req_valid && (st_q == ST_IDLE);
  assign launch  = accept && hit;

  amt_tick_gen u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (launch),
    .run_i    (running),
    .div_m1_i (cur_q.div_m1),
    .cnt_o    (cnt),
    .first_o  (first)
  );

  assign len     = wr_q ? cur_q.wr_len : cur_q.rd_len;
  assign at_end  = running && (cnt == len);
  assign capture = running && !wr_q && first && (cnt == cur_q.acc_tick);

  always_comb begin
    st_d = st_q;
    if (launch)      st_d = ST_RUN;
    else if (at_end) st_d = ST_IDLE;
    done_d = at_end;
    err_d  = accept && !hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      wr_q    <= 1'b0;
      sel_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (launch) begin
      cur_q   <= cfg_all[hit_sel];
      wr_q    <= req_write;
      sel_q   <= hit_sel;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdat_q <= '0;
    else if (capture) rdat_q <= mem_din;
  end

  logic cs_act, adv_act, oe_act, we_act, addr_phase;

  assign cs_act  = running && in_window(cnt, cur_q.cs_on,
                                        wr_q ? cur_q.cs_wr_off : cur_q.cs_rd_off);
  assign adv_act = running && in_window(cnt, cur_q.adv_on,
                                        wr_q ? cur_q.adv_wr_off : cur_q.adv_rd_off);
  assign oe_act  = running && !wr_q && in_window(cnt, cur_q.oe_on, cur_q.oe_off);
  assign we_act  = running &&  wr_q && in_window(cnt, cur_q.we_on, cur_q.we_off);
  assign addr_phase = cur_q.muxed && adv_act;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_csn
    assign mem_cs_n[g] = !(cs_act && (sel_q == SEL_W'(g)));
  end

  assign mem_adv_n   = !adv_act;
  assign mem_oe_n    = !oe_act;
  assign mem_we_n    = !we_act;
  assign mem_addr    = addr_q;
  assign mem_dout    = addr_phase ? addr_q[DATA_W-1:0] : wdata_q;
  assign mem_dout_en = addr_phase || (wr_q && cs_act);
  assign done        = done_q;
  assign err         = err_q;
  assign rd_data     = rdat_q;

  // R6: completion is a single-clock pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: an error pulse coincides with fully quiet strobes
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ((&mem_cs_n) && mem_adv_n && mem_oe_n && mem_we_n));

  // R4: read and write enables never overlap
  assert_rw_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R8: at most one chip select low
  assert_one_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  // R12: idle means every strobe inactive and no drive
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> ((&mem_cs_n) && mem_adv_n && mem_oe_n && mem_we_n && !mem_dout_en));

  // R10: the captured address does not move during an access
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !at_end) |=> $stable(mem_addr));

endmodule

// File: tb/amt_engine_test.sv
`timescale 1ns/1ps
module amt_engine_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [0:0]  cfg_cs;
  logic [2:0]  cfg_word;
  logic [31:0] cfg_wdata;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [15:0] req_wdata;
  logic        done, err;
  logic [15:0] rd_data;
  logic [1:0]  mem_cs_n;
  logic        mem_adv_n, mem_oe_n, mem_we_n;
  logic [31:0] mem_addr;
  logic [15:0] mem_dout;
  logic        mem_dout_en;
  logic [15:0] mem_din;

  always #2.5 clk = ~clk;

  amt_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cs(cfg_cs),
    .cfg_word(cfg_word), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .err(err), .rd_data(rd_data), .mem_cs_n(mem_cs_n),
    .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // timing set currently loaded into the bench model
  int t_cs_on, t_cs_rd, t_cs_wr, t_adv_on, t_adv_rd, t_adv_wr;
  int t_oe_on, t_oe_off, t_we_on, t_we_off, t_rd_len, t_wr_len, t_acc;
  int m_div, m_mux;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_set(input int s);
    case (s)
      0: begin
        t_cs_on=0; t_cs_rd=8;  t_cs_wr=7;  t_adv_on=0; t_adv_rd=2; t_adv_wr=3;
        t_oe_on=3; t_oe_off=8; t_we_on=2;  t_we_off=6; t_rd_len=9; t_wr_len=8; t_acc=6;
      end
      1: begin
        t_cs_on=1; t_cs_rd=12; t_cs_wr=10; t_adv_on=1; t_adv_rd=3; t_adv_wr=4;
        t_oe_on=5; t_oe_off=11; t_we_on=4; t_we_off=9; t_rd_len=12; t_wr_len=11; t_acc=10;
      end
      default: begin
        t_cs_on=0; t_cs_rd=31; t_cs_wr=5;  t_adv_on=0; t_adv_rd=0; t_adv_wr=0;
        t_oe_on=2; t_oe_off=2; t_we_on=15; t_we_off=31; t_rd_len=5; t_wr_len=20; t_acc=5;
      end
    endcase
  endtask

  task automatic cfg_write(input int cs, input int word, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cs = 1'(cs); cfg_word = 3'(word); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R1: program word 0..4 with the layout stated in the requirement
  task automatic prog(input int cs, input int base, input int en, input int div, input int mux);
    cfg_write(cs, 0, 32'((div-1) | (mux<<2) | (en<<3) | (base<<8)));
    cfg_write(cs, 1, 32'(t_cs_on | (t_cs_rd<<8) | (t_cs_wr<<16)));
    cfg_write(cs, 2, 32'(t_adv_on | (t_adv_rd<<8) | (t_adv_wr<<16)));
    cfg_write(cs, 3, 32'(t_oe_on | (t_oe_off<<8) | (t_we_on<<16) | (t_we_off<<24)));
    cfg_write(cs, 4, 32'(t_rd_len | (t_wr_len<<8) | (t_acc<<16)));
    m_div = div; m_mux = mux;
  endtask

  function automatic logic [15:0] pat(input int k, input int seed);
    return 16'(16'hA55A ^ (k * 16'h0123) ^ (seed * 16'h1111));
  endfunction

  task automatic run_access(input int cs, input int wr, input logic [31:0] addr,
                            input logic [15:0] wd, input bit poke, input int seed);
    int n, len, mm_cs, mm_adv, mm_oerw, mm_dout, mm_done;
    logic [15:0] cap;
    len = wr ? t_wr_len : t_rd_len;
    n = len * m_div;
    mm_cs = 0; mm_adv = 0; mm_oerw = 0; mm_dout = 0; mm_done = 0;
    cap = pat(t_acc * m_div, seed);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr[0]; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k <= n + 2; k++) begin
      int c;
      bit act, cs_a, adv_a, oe_a, we_a, den;
      logic [1:0] ecs;
      logic [15:0] edout;
      mem_din = pat(k, seed);
      if (poke && k == 1) begin
        req_valid = 1'b1; req_write = ~wr[0];
        req_addr = {3'b0, 5'd17, 24'h00ABCD}; req_wdata = 16'hDEAD;
      end else begin
        req_valid = 1'b0;
      end
      act = (k <= n);
      c = k / m_div;
      cs_a  = act && c >= t_cs_on  && c < (wr ? t_cs_wr  : t_cs_rd);
      adv_a = act && c >= t_adv_on && c < (wr ? t_adv_wr : t_adv_rd);
      oe_a  = act && !wr && c >= t_oe_on && c < t_oe_off;
      we_a  = act &&  wr && c >= t_we_on && c < t_we_off;
      ecs = 2'b11;
      if (cs_a) ecs[cs] = 1'b0;
      den = (m_mux != 0 && adv_a) || (wr != 0 && cs_a);
      edout = (m_mux != 0 && adv_a) ? addr[15:0] : wd;
      if (mem_cs_n !== ecs) mm_cs++;
      if (mem_adv_n !== !adv_a) mm_adv++;
      if (mem_oe_n !== !oe_a || mem_we_n !== !we_a) mm_oerw++;
      if (mem_dout_en !== den || (den && mem_dout !== edout)) mm_dout++;
      if (done !== (k == n + 1)) mm_done++;
      if (k == n + 1 && wr == 0)
        chk(rd_data === cap, "R7 read capture", int'(rd_data), int'(cap));
      @(negedge clk);
    end
    chk(mm_cs == 0, "R2 R5 chip-select window mismatches", mm_cs, 0);
    chk(mm_adv == 0, "R3 address-valid window mismatches", mm_adv, 0);
    chk(mm_oerw == 0, "R4 oe/we window mismatches", mm_oerw, 0);
    chk(mm_dout == 0, "R11 data drive mismatches", mm_dout, 0);
    chk(mm_done == 0, "R6 done timing mismatches", mm_done, 0);
    if (poke)
      chk(mem_cs_n === 2'b11 && !done, "R10 busy request ignored", int'(mem_cs_n), 3);
  endtask

  task automatic run_err(input logic [31:0] addr, input string tag);
    int bad;
    bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err === 1'b1, tag, int'(err), 1);
    for (int k = 0; k < 4; k++) begin
      if (mem_cs_n !== 2'b11 || !mem_adv_n || !mem_oe_n || !mem_we_n || done) bad++;
      if (k > 0 && err) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9 no strobe and single err pulse", bad, 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_cs = '0; cfg_word = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; mem_din = '0;
    repeat (3) @(negedge clk);
    chk(mem_cs_n === 2'b11 && mem_adv_n && mem_oe_n && mem_we_n,
        "R12 strobes high in reset", int'(mem_cs_n), 3);
    chk(!done && !err && !mem_dout_en, "R12 pulses low in reset", int'(done|err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_cs_n === 2'b11 && !done && !err, "R12 idle after reset", int'(mem_cs_n), 3);

    load_set(0);
    prog(0, 3, 1, 1, 0);
    prog(1, 17, 1, 1, 0);

    for (int d = 1; d <= 4; d++) begin
      for (int s = 0; s < 3; s++) begin
        for (int w = 0; w < 2; w++) begin
          int cs, base;
          cs = (s + w + d) % 2;
          base = cs ? 17 : 3;
          load_set(s);
          prog(cs, base, 1, d, (s == 1) ? 1 : 0);
          run_access(cs, w, {3'b0, 5'(base), 24'(24'h001234 + s*16 + w)},
                     16'(16'h5A00 + d*16 + s*2 + w), (w == 1 && s == 0), d*8 + s*2 + w);
        end
      end
    end

    run_err({3'b0, 5'd31, 24'h000100}, "R9 unmatched base raises err");
    cfg_write(1, 0, 32'((17<<8) | (0<<3)));
    run_err({3'b0, 5'd17, 24'h000100}, "R8 R9 disabled chip select gives err");

    load_set(0);
    prog(0, 3, 1, 2, 0);
    prog(1, 3, 1, 1, 0);
    m_div = 2; m_mux = 0;
    run_access(0, 0, {3'b0, 5'd3, 24'h000777}, 16'h1357, 1'b0, 99);
    chk(mem_cs_n === 2'b11, "R8 duplicate base picked lowest index", int'(mem_cs_n), 3);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule